// File: doc/BRIEF.md
# Interleaved Test Pattern Playback Store

This block is an on-chip pattern memory that drives a 6-bit segmented current-steering DAC core during test. A pattern of 4992 bits enters from off-chip through a slow serial pin, one bit per clock. The same storage then plays the pattern back forever as a stream of 6-bit codes. No further loading is needed.

The store is 48 shift registers of 104 bits. They are grouped as 8 lanes of 6 code bits. During a load they form one long serial chain. During replay each register rotates on itself. Every register steps on the same enable in both modes, so the switching activity is the same whatever the stored data. An 8:1 lane selector takes one sample from each lane in turn. After each full round of the lanes, all registers advance by one position together, which gives a loop of 832 samples.

Each output code is also split for the DAC cells. The upper 3 bits become a 7-cell thermometer word and the lower 3 bits pass through as the binary-weighted part. All outputs are registered.

Top module: `ilv_pattern_player`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets. After that edge `dac_code` is 6'b100000, `therm_code` is 7'b0001111, `bin_code` is 0, `lane_idx` is 0 and `load_done` is 0.
- R2: `load_done` is 0 after 4991 consecutive load cycles of a load session and 1 after 4992 of them. It then holds, including through replay, until the first cycle of the next load session clears it. A load session starts at a load cycle that follows a replay cycle or a reset.
- R3: After every clock edge at which `load_en` is high, `dac_code` is 6'b100000 (mid-scale), with the matching `therm_code` 7'b0001111 and `bin_code` 0.
- R4: Number the serial bits of a load 0, 1, 2 and so on, with bit 0 loaded first, and let k be one of those numbers. Bit k is stored for lane l = (k/104)/6, code bit b = (k/104)%6, frame f = k%104. In replay, output sample n carries in its bit b the stored bit of lane n%8, frame (n/8)%104.
- R5: Replay repeats the same 832-sample sequence indefinitely without any reload.
- R6: `lane_idx` reports the lane of the sample currently on `dac_code`. It is 0 for the first sample after a load or reset and increases by one, modulo 8, for each following sample.
- R7: `therm_code` bit j is 1 exactly when j is less than `dac_code[5:3]`, so the lit cells always form an unbroken run from cell 0.
- R8: `bin_code` equals `dac_code[2:0]` in the same cycle.
- R9: Replay sample n appears on the outputs right after the (n+1)-th clock edge at which `load_en` is low. This is one register stage, counted from the first such edge, numbered n = 0.
- R10: If more than 4992 bits are shifted in during one load session, only the last 4992 are kept. They map as in R4, counting from the first of those 4992 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | 1 = serial load, 0 = replay |
| load_bit | input | 1 | Serial pattern bit, taken on each load cycle |
| load_done | output | 1 | Set once a full pattern has been shifted in |
| lane_idx | output | 3 | Lane that supplied the current output sample |
| dac_code | output | 6 | Current DAC code |
| therm_code | output | 7 | Thermometer word for the upper code bits |
| bin_code | output | 3 | Binary part of the code |

## Verification
Every result leaves through exactly one register stage. An output reflects the inputs present at the edge just before it: a load cycle shows mid-scale after that edge, `load_done` rises after the 4992nd load edge, and replay sample n shows after the (n+1)-th replay edge. The bench drives inputs on the falling edge. It compares on the next falling edge against a model that counts those edges: it checks `load_done` at 4991 and 4992 load edges, and it checks the replay sample at edge count n against the code built from the loaded bits. Replay runs beyond 832 samples to show the loop wrap, and one load overfills the chain to show that the oldest bits are discarded.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic {
    TPM_REPLAY = 1'b0,
    TPM_LOAD   = 1'b1
  } tpm_mode_e;
endpackage

// File: rtl/tpm_load_ctrl.sv
module tpm_load_ctrl #(
  parameter int TOTAL = 4992
) (
  input  logic clk,
  input  logic rst,
  input  logic load_en,
  output logic load_done
);
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             was_load;
  logic             done_q;

  // A session starts on the first load cycle after replay or reset.
  always_comb begin
    if (!was_load)                 cnt_nxt = CNT_W'(1);
    else if (cnt == CNT_W'(TOTAL)) cnt_nxt = cnt;
    else                           cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      was_load <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      was_load <= load_en;
      if (load_en) begin
        cnt    <= cnt_nxt;
        done_q <= (cnt_nxt == CNT_W'(TOTAL));
      end
    end
  end

  assign load_done = done_q;
endmodule

// File: rtl/tpm_lane_seq.sv
module tpm_lane_seq #(
  parameter int LANES = 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  output logic [LANE_W-1:0] phase,
  output logic              frame_end
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

  always_ff @(posedge clk) begin
    if (rst || load_en)      phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + LANE_W'(1);
  end

  assign frame_end = !load_en && (phase == LAST);
endmodule

// File: rtl/tpm_shift_store.sv
module tpm_shift_store
  import tpm_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int CODE_W = 6,
  parameter int DEPTH  = 104,
  localparam int NREG  = LANES * CODE_W
) (
  input  logic            clk,
  input  logic            shift_en,
  input  tpm_mode_e       mode,
  input  logic            load_bit,
  output logic [NREG-1:0] heads
);
  logic [DEPTH-1:0] sreg [NREG];
  logic [NREG-1:0]  feed;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == NREG - 1) begin : g_tail
      assign feed[r] = (mode == TPM_LOAD) ? load_bit : sreg[r][0];
    end else begin : g_link
      assign feed[r] = (mode == TPM_LOAD) ? sreg[r+1][0] : sreg[r][0];
    end

    // Every register steps on the common enable, independent of contents.
    always_ff @(posedge clk) begin
      if (shift_en) sreg[r] <= {feed[r], sreg[r][DEPTH-1:1]};
    end

    assign heads[r] = sreg[r][0];
  end
endmodule

// File: rtl/tpm_seg_decode.sv
module tpm_seg_decode #(
  parameter int CODE_W = 6,
  parameter int BIN_W  = 3,
  localparam int UNARY_W = CODE_W - BIN_W,
  localparam int THERM_W = (1 << UNARY_W) - 1
) (
  input  logic [CODE_W-1:0]  code,
  output logic [THERM_W-1:0] therm,
  output logic [BIN_W-1:0]   bin
);
  logic [UNARY_W-1:0] upper;
  assign upper = code[CODE_W-1 -: UNARY_W];
  assign bin   = code[BIN_W-1:0];

  for (genvar j = 0; j < THERM_W; j++) begin : g_cell
    assign therm[j] = (upper > UNARY_W'(j));
  end
endmodule

// File: rtl/ilv_pattern_player.sv
module ilv_pattern_player
  import tpm_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int CODE_W = 6,
  parameter int BIN_W  = 3,
  parameter int DEPTH  = 104,
  localparam int LANE_W  = $clog2(LANES),
  localparam int NREG    = LANES * CODE_W,
  localparam int TOTAL   = NREG * DEPTH,
  localparam int THERM_W = (1 << (CODE_W - BIN_W)) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               load_bit,
  output logic               load_done,
  output logic [LANE_W-1:0]  lane_idx,
  output logic [CODE_W-1:0]  dac_code,
  output logic [THERM_W-1:0] therm_code,
  output logic [BIN_W-1:0]   bin_code
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  tpm_mode_e          mode;
  logic [LANE_W-1:0]  phase;
  logic               frame_end;
  logic               shift_en;
  logic [NREG-1:0]    heads;
  logic [CODE_W-1:0]  lane_code;
  logic [CODE_W-1:0]  code_nxt;
  logic [THERM_W-1:0] therm_nxt;
  logic [BIN_W-1:0]   bin_nxt;

  assign mode     = load_en ? TPM_LOAD : TPM_REPLAY;
  assign shift_en = !rst && (load_en || frame_end);

  tpm_load_ctrl #(.TOTAL(TOTAL)) u_load (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_done (load_done)
  );

  tpm_lane_seq #(.LANES(LANES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .phase     (phase),
    .frame_end (frame_end)
  );

  tpm_shift_store #(.LANES(LANES), .CODE_W(CODE_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .shift_en (shift_en),
    .mode     (mode),
    .load_bit (load_bit),
    .heads    (heads)
  );

  assign lane_code = heads[phase*CODE_W +: CODE_W];
  assign code_nxt  = (rst || load_en) ? MID : lane_code;

  tpm_seg_decode #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_dec (
    .code  (code_nxt),
    .therm (therm_nxt),
    .bin   (bin_nxt)
  );

  always_ff @(posedge clk) begin
    dac_code   <= code_nxt;
    therm_code <= therm_nxt;
    bin_code   <= bin_nxt;
    lane_idx   <= (rst || load_en) ? '0 : phase;
  end
endmodule

// File: rtl/ilv_pattern_player_chk.sv
module ilv_pattern_player_chk #(
  parameter int LANE_W  = 3,
  parameter int CODE_W  = 6,
  parameter int BIN_W   = 3,
  parameter int THERM_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               load_en,
  input logic               load_done,
  input logic [LANE_W-1:0]  lane_idx,
  input logic [CODE_W-1:0]  dac_code,
  input logic [THERM_W-1:0] therm_code,
  input logic [BIN_W-1:0]   bin_code
);
  localparam int UNARY_W = CODE_W - BIN_W;

  p_mid_load_r3: assert property (@(posedge clk) disable iff (rst)
    $past(load_en) |-> dac_code == (CODE_W'(1) << (CODE_W - 1)));

  p_therm_count_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(therm_code) == int'(dac_code[CODE_W-1 -: UNARY_W]));

  p_therm_run_r7: assert property (@(posedge clk) disable iff (rst)
    (THERM_W'(therm_code + 1'b1) & therm_code) == '0);

  p_bin_pass_r8: assert property (@(posedge clk) disable iff (rst)
    bin_code == dac_code[BIN_W-1:0]);

  p_lane_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !$past(load_en) && !$past(rst)) |=>
      lane_idx == LANE_W'($past(lane_idx) + 1'b1));

  p_lane_start_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_en && $past(load_en)) |=> lane_idx == '0);

  p_done_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (load_done && !(load_en && !$past(load_en))) |=> load_done);

  p_done_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(load_done) |-> $past(load_en));
endmodule

bind ilv_pattern_player ilv_pattern_player_chk #(
  .LANE_W(LANE_W), .CODE_W(CODE_W), .BIN_W(BIN_W), .THERM_W(THERM_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_en    (load_en),
  .load_done  (load_done),
  .lane_idx   (lane_idx),
  .dac_code   (dac_code),
  .therm_code (therm_code),
  .bin_code   (bin_code)
);

// File: tb/test_ilv_pattern_player.sv
`timescale 1ns/1ps
module test_ilv_pattern_player;
  localparam int LANES  = 8;
  localparam int CODE_W = 6;
  localparam int DEPTH  = 104;
  localparam int TOTAL  = LANES * CODE_W * DEPTH;
  localparam int LOOP   = LANES * DEPTH;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic       load_bit = 1'b0;
  logic       load_done;
  logic [2:0] lane_idx;
  logic [5:0] dac_code;
  logic [6:0] therm_code;
  logic [2:0] bin_code;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  ilv_pattern_player i_ilv_pattern_player (
    .clk(clk), .rst(rst), .load_en(load_en), .load_bit(load_bit),
    .load_done(load_done), .lane_idx(lane_idx), .dac_code(dac_code),
    .therm_code(therm_code), .bin_code(bin_code)
  );

  function automatic logic pat_bit(int k, int seed);
    logic [31:0] h;
    h = k * 32'h9E3779B1 + seed * 32'h7F4A7C15;
    h = h ^ (h >> 13);
    return h[17] ^ h[29] ^ h[5];
  endfunction

  function automatic logic [5:0] exp_code(int n, int seed);
    logic [5:0] c;
    int f = (n / LANES) % DEPTH;
    int l = n % LANES;
    for (int b = 0; b < CODE_W; b++) c[b] = pat_bit((l * CODE_W + b) * DEPTH + f, seed);
    return c;
  endfunction

  function automatic logic [6:0] exp_therm(logic [5:0] c);
    logic [6:0] t;
    for (int j = 0; j < 7; j++) t[j] = (j < int'(c[5:3]));
    return t;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_mid(string req);
    chk({req, " mid code"}, 32'(dac_code), 32'h20);
    chk({req, " mid therm"}, 32'(therm_code), 32'h0F);
    chk({req, " mid bin"}, 32'(bin_code), 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; load_en = 1'b0;
    repeat (2) @(negedge clk);
    check_mid("R1");
    chk("R1 lane", 32'(lane_idx), 0);
    chk("R1 done", 32'(load_done), 0);
    rst = 1'b0;
  endtask

  // Drives extra junk bits first, then the pattern; ends at a negedge with load_en still high.
  task automatic t_load(int seed, int extra);
    for (int i = 0; i < TOTAL + extra; i++) begin
      @(negedge clk);
      if (i == 1) chk("R2 new session clears done", 32'(load_done), 0);
      if (i > 0 && (i % 700) == 1) check_mid("R3");
      if (extra == 0 && i == TOTAL - 1) chk("R2 done at 4991", 32'(load_done), 0);
      if (extra > 0 && i == TOTAL) chk("R2 done at 4992", 32'(load_done), 1);
      load_en  = 1'b1;
      load_bit = (i < extra) ? ~pat_bit(i, seed + 99) : pat_bit(i - extra, seed);
    end
    @(negedge clk);
    chk("R2 done after full load", 32'(load_done), 1);
    check_mid("R3 last load");
  endtask

  task automatic t_replay(int seed, int nsamp, string req);
    logic [5:0] e;
    load_en = 1'b0;
    for (int n = 0; n < nsamp; n++) begin
      @(negedge clk);
      e = exp_code(n, seed);
      chk((n < LOOP) ? {req, " R4 R9 code"} : {req, " R5 wrap code"}, 32'(dac_code), 32'(e));
      chk("R6 lane", 32'(lane_idx), 32'(n % LANES));
      chk("R7 therm", 32'(therm_code), 32'(exp_therm(e)));
      chk("R8 bin", 32'(bin_code), 32'(e[2:0]));
    end
    chk("R2 done held in replay", 32'(load_done), 1);
  endtask

  initial begin
    t_reset();
    t_load(1, 0);
    t_replay(1, 2 * LOOP + 40, "seed1");
    t_load(2, 37);
    t_replay(2, LOOP + 20, "R10 overfill");
    t_reset();
    t_load(3, 0);
    t_replay(3, 64, "seed3");
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule